// File: doc/BRIEF.md
# Switch-Programmed Square Wave Generator

This block turns a free-running clock into a square wave whose frequency comes from an 8-bit value set on a bank of switches. The switch value is first passed through two register stages, because it comes from outside the clock domain. A counter then toggles the output each time it hits a terminal count. No divider is built at run time.

A parameter selects how the terminal count is found. In table mode, a constant base count (25,000,000 by default) is divided by every possible switch value at elaboration. The switch value then indexes that table of constants, so each half-period lasts floor(base / v) + 1 clock cycles. In stepping mode, the counter advances by the switch value on every clock and is compared against one fixed terminal count. A larger value therefore shortens the period in direct proportion. A switch value of zero parks the generator with its output low.

Top module: `sqwave_gen`

## Requirements
- R1: A synchronous active-high `rst` forces `wave` low and clears the counter and both synchroniser stages on the clock edge where it is sampled high. After release, counting restarts from zero exactly as it does after leaving the zero setting (R2).
- R2: `sw` is registered twice before use. In table mode, going from a parked (zero) state to a value v makes `wave` rise on the (floor(BASE_COUNT/v) + 3)-th clock edge after `sw` changes.
- R3: In table mode (`STEP_MODE` = 0), the terminal count for value v is floor(BASE_COUNT / v), held as an elaboration-time constant. In steady state, every high phase and every low phase of `wave` lasts that count plus one cycles.
- R4: In table mode, when the counter equals the terminal count, `wave` inverts and the counter returns to zero. When the counter is below it, the counter adds one and `wave` holds.
- R5: In either mode, while the synchronised switch value is zero, `wave` is driven low and the counter is held at zero.
- R6: In table mode, if a new switch value has a terminal count below the current counter, the counter is cleared without toggling on the first edge that uses the new value. The next toggle follows terminal count + 1 edges later.
- R7: In stepping mode (`STEP_MODE` = 1), each edge adds v to the counter. When the sum reaches or passes STEP_TERM, `wave` inverts and the counter keeps sum − STEP_TERM, so the counter always stays below STEP_TERM. When v divides STEP_TERM, every phase lasts STEP_TERM / v cycles. From a parked state, the first rise comes on edge STEP_TERM / v + 2.
- R8: `STEP_MODE` selects between the two modes at elaboration, and both variants share the same port list.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sw | input | SW_W (8) | Frequency setting from switches, asynchronous |
| wave | output | 1 | Square wave output |

## Verification
The synchroniser adds two cycles between a switch change and its first effect. The table-mode counter then needs terminal count + 1 edges before the first toggle. The bench therefore expects 103 cycles for the first rise at v = 10 with a base of 1000, and 104 cycles after an overshoot clear started at count 150. It counts negative edges from the moment it drives `sw` to the moment `wave` differs.

For steady-state periods, the driver waits two toggles after a change so that any interval spanning the change drops out. Only then does it queue the expected phase lengths. The monitor measures the cycles between output changes on negative edges and compares each one against the queue.

// File: rtl/sqwave_gen.sv
`timescale 1ns/1ps
module sqwave_gen #(
  parameter int SW_W       = 8,
  parameter int BASE_COUNT = 25_000_000,
  parameter int STEP_MODE  = 0,
  parameter int STEP_TERM  = 25_000_000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SW_W-1:0] sw,
  output logic            wave
);
  localparam int NVAL    = 1 << SW_W;
  localparam int LUT_CW  = $clog2(BASE_COUNT + 1);
  localparam int STEP_CW = $clog2(STEP_TERM + NVAL);
  localparam int CW      = (STEP_MODE != 0) ? STEP_CW : LUT_CW;

  logic [SW_W-1:0] sw_m, sw_s;
  logic [CW-1:0]   cnt, tc;
  logic            wave_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_m <= '0;
      sw_s <= '0;
    end else begin
      sw_m <= sw;
      sw_s <= sw_m;
    end
  end

  generate
    if (STEP_MODE == 0) begin : g_table
      logic [CW-1:0] lut [NVAL];
      for (genvar i = 0; i < NVAL; i++) begin : g_ent
        localparam int TCI = (i == 0) ? 0 : BASE_COUNT / i;
        assign lut[i] = CW'(TCI);
      end
      assign tc = lut[sw_s];

      always_ff @(posedge clk) begin
        if (rst || sw_s == '0) begin
          cnt    <= '0;
          wave_q <= 1'b0;
        end else if (cnt == tc) begin
          cnt    <= '0;
          wave_q <= ~wave_q;
        end else if (cnt > tc) begin
          cnt    <= '0;
        end else begin
          cnt    <= cnt + CW'(1);
        end
      end
    end else begin : g_step
      logic [CW-1:0] sum;
      assign tc  = CW'(STEP_TERM);
      assign sum = cnt + CW'(sw_s);

      always_ff @(posedge clk) begin
        if (rst || sw_s == '0) begin
          cnt    <= '0;
          wave_q <= 1'b0;
        end else if (sum >= tc) begin
          cnt    <= sum - tc;
          wave_q <= ~wave_q;
        end else begin
          cnt    <= sum;
        end
      end
    end
  endgenerate

  assign wave = wave_q;
endmodule

// File: rtl/sqwave_gen_chk.sv
`timescale 1ns/1ps
module sqwave_gen_chk #(
  parameter int SW_W      = 8,
  parameter int CW        = 25,
  parameter int STEP_MODE = 0
) (
  input logic            clk,
  input logic            rst,
  input logic [SW_W-1:0] sw_s,
  input logic [CW-1:0]   cnt,
  input logic [CW-1:0]   tc,
  input logic            wave
);
  assert_zero_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (sw_s == '0) |=> (cnt == '0 && !wave));

  generate
    if (STEP_MODE == 0) begin : g_table_chk
      assert_toggle_at_tc_R4: assert property (@(posedge clk) disable iff (rst)
        (sw_s != '0 && cnt == tc) |=> (cnt == '0 && wave != $past(wave)));
      assert_count_up_R4: assert property (@(posedge clk) disable iff (rst)
        (sw_s != '0 && cnt < tc) |=> (cnt == CW'($past(cnt) + 1'b1) && $stable(wave)));
      assert_overshoot_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (sw_s != '0 && cnt > tc) |=> (cnt == '0 && $stable(wave)));
    end else begin : g_step_chk
      assert_below_term_R7: assert property (@(posedge clk) disable iff (rst)
        cnt < tc);
      assert_step_toggle_R7: assert property (@(posedge clk) disable iff (rst)
        (sw_s != '0 && (cnt + CW'(sw_s)) >= tc) |=> (wave != $past(wave)));
    end
  endgenerate
endmodule

bind sqwave_gen sqwave_gen_chk #(.SW_W(SW_W), .CW(CW), .STEP_MODE(STEP_MODE)) u_chk (
  .clk(clk), .rst(rst), .sw_s(sw_s), .cnt(cnt), .tc(tc), .wave(wave));

// File: tb/sqwave_gen_bench.sv
`timescale 1ns/1ps
module sqwave_gen_bench;
  localparam int BASE = 1000;
  localparam int STEP = 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] sw_a = '0, sw_b = '0;
  logic out_a, out_b;
  int n_checks = 0, n_fail = 0;
  int q_a[$], q_b[$];
  int run_a = 0, run_b = 0;
  logic pa = 1'b0, pb = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sqwave_gen #(.SW_W(8), .BASE_COUNT(BASE), .STEP_MODE(0), .STEP_TERM(STEP)) u_sqwave_gen (
    .clk(clk), .rst(rst), .sw(sw_a), .wave(out_a));
  sqwave_gen #(.SW_W(8), .BASE_COUNT(BASE), .STEP_MODE(1), .STEP_TERM(STEP)) u_sqwave_gen_step (
    .clk(clk), .rst(rst), .sw(sw_b), .wave(out_b));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    run_a++;
    if (out_a !== pa) begin
      if (q_a.size() > 0) begin
        int e;
        e = q_a.pop_front();
        check(run_a == e, "R3 table phase length", run_a, e);
      end
      run_a = 0;
    end
    pa = out_a;
  end

  always @(negedge clk) begin
    run_b++;
    if (out_b !== pb) begin
      if (q_b.size() > 0) begin
        int e;
        e = q_b.pop_front();
        check(run_b == e, "R7 step phase length", run_b, e);
      end
      run_b = 0;
    end
    pb = out_b;
  end

  task automatic wait_toggle(input bit sel);
    logic p;
    p = sel ? out_b : out_a;
    do @(negedge clk); while ((sel ? out_b : out_a) === p);
  endtask

  task automatic cycles_to_change(input bit sel, output int k);
    logic p;
    p = sel ? out_b : out_a;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while ((sel ? out_b : out_a) === p && k < 5000);
  endtask

  task automatic drive_table(input int v, input int n);
    @(negedge clk) sw_a = 8'(v);
    wait_toggle(0);
    wait_toggle(0);
    @(posedge clk);
    for (int i = 0; i < n; i++) q_a.push_back(BASE / v + 1);
    while (q_a.size() > 0) @(negedge clk);
  endtask

  task automatic drive_step(input int v, input int n);
    @(negedge clk) sw_b = 8'(v);
    wait_toggle(1);
    wait_toggle(1);
    @(posedge clk);
    for (int i = 0; i < n; i++) q_b.push_back(STEP / v);
    while (q_b.size() > 0) @(negedge clk);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    int k;
    bit low_ok;
    repeat (3) @(negedge clk);
    check(out_a === 1'b0, "R1 reset table", out_a, 0);
    check(out_b === 1'b0, "R1 reset step", out_b, 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    check(out_a === 1'b0 && out_b === 1'b0, "R5 parked after reset", out_a | out_b, 0);

    drive_table(10, 4);
    drive_table(7, 3);
    drive_table(255, 6);
    drive_table(2, 2);

    drive_step(100, 4);
    drive_step(250, 6);
    drive_step(8, 3);
    drive_step(200, 5);

    // R5: zero parks output low (table), then R2 latency on resume
    @(negedge clk) sw_a = 8'd10;
    while (out_a !== 1'b1) @(negedge clk);
    sw_a = 8'd0;
    repeat (4) @(negedge clk);
    low_ok = 1;
    for (int i = 0; i < 100; i++) begin
      if (out_a !== 1'b0) low_ok = 0;
      @(negedge clk);
    end
    check(low_ok, "R5 table zero holds low", out_a, 0);
    sw_a = 8'd10;
    cycles_to_change(0, k);
    check(k == 103, "R2 resume latency", k, 103);

    // R5 and R7 on stepping instance
    while (out_b !== 1'b1) @(negedge clk);
    sw_b = 8'd0;
    repeat (4) @(negedge clk);
    low_ok = 1;
    for (int i = 0; i < 50; i++) begin
      if (out_b !== 1'b0) low_ok = 0;
      @(negedge clk);
    end
    check(low_ok, "R5 step zero holds low", out_b, 0);
    sw_b = 8'd100;
    cycles_to_change(1, k);
    check(k == 12, "R7 step first rise", k, 12);

    // R6: overshoot clear
    sw_a = 8'd5;
    wait_toggle(0);
    wait_toggle(0);
    repeat (150) @(negedge clk);
    sw_a = 8'd10;
    cycles_to_change(0, k);
    check(k == 104, "R6 overshoot clear", k, 104);

    // R1: mid-run reset
    while (out_a !== 1'b1) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(out_a === 1'b0, "R1 mid-run reset", out_a, 0);
    rst = 1'b0;
    cycles_to_change(0, k);
    check(k == 103, "R1 restart after reset", k, 103);

    // R8: both variants ran from the same ports with different behaviour
    check(n_checks > 30, "R8 both modes exercised", n_checks, 31);
    finish_up();
  end
endmodule